// File: doc/BRIEF.md
# Flash Read Holding Register Buffer

This block keeps one read result from a slow flash array so that a repeat read of the same address can be answered at once. When the array finishes a read without error, the block stores the returned word, its full address and a flag that marks a corrected single-bit ECC event. A later bus read to that address is a hit. The stored word, and the stored flag, are returned in the first data-phase cycle with no wait states.

Several events drop the stored entry. The array-done signal falling to show the start of a program or erase drops it. A non-sequential access with a non-zero wait-state emulation field drops it. A software enable bit held low drops it. A completion that reports a transfer error never leaves the entry valid. Data marked with a corrected ECC event is still stored, and the flag is returned on every hit. Software can then clear the enable bit after the first alert so the alert does not repeat.

Top module: `flash_rdbuf`

## Requirements
- R1: An array completion (`fill_valid`=1, `fill_err`=0) with no invalidation in that cycle stores `fill_addr`, `fill_data` and `fill_ecc1` and makes the entry valid from the next cycle.
- R2: A lookup is a transfer with `htrans` NONSEQ (2'b10) or SEQ (2'b11). A lookup whose `haddr` equals the stored address while the entry is valid gives `rsp_hit`=1 and the stored word on `rsp_data` in the cycle after the address phase. Every other cycle gives `rsp_hit`=0 and `rsp_data`=0.
- R3: A high-to-low change of `arr_done` invalidates the entry, and a lookup in that cycle misses. A level that stays low and a rising change have no effect.
- R4: A NONSEQ lookup with `haddr[28:24]` non-zero invalidates the entry and misses. A SEQ lookup with that field non-zero does not invalidate, and neither does a NONSEQ lookup with that field zero.
- R5: While `buf_en` is 0 the entry is invalidated and lookups miss. After `buf_en` returns to 1, the entry stays invalid until a new load.
- R6: A completion with `fill_err`=1 leaves the entry invalid, even if it held valid data before.
- R7: The stored ECC flag appears on `rsp_ecc` with every hit on that entry. `rsp_ecc` is 0 whenever `rsp_hit` is 0.
- R8: IDLE (2'b00) and BUSY (2'b01) transfers never hit and never invalidate.
- R9: When an invalidation condition and a completion fall in the same cycle, the entry ends invalid.
- R10: Reset (synchronous, `rst_n`=0) leaves the entry invalid with the ECC flag cleared, and drives `rsp_hit`, `rsp_ecc` and `rsp_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| htrans | input | 2 | Bus transfer type of the current address phase |
| haddr | input | ADDR_W | Address of the current address phase |
| buf_en | input | 1 | Software buffer enable; 0 invalidates |
| arr_done | input | 1 | Array idle indicator; 0 means program/erase in progress |
| fill_valid | input | 1 | Array read completion strobe |
| fill_addr | input | ADDR_W | Address of the completed array read |
| fill_data | input | DATA_W | Data returned by the array |
| fill_err | input | 1 | Completion ended with a transfer error |
| fill_ecc1 | input | 1 | Completion carried a corrected single-bit ECC event |
| rsp_hit | output | 1 | Data-phase hit indication |
| rsp_data | output | DATA_W | Data-phase read data from the buffer (0 on miss) |
| rsp_ecc | output | 1 | Stored ECC flag returned with a hit |

## Verification
A stale valid bit shows at the ports as a hit right after an event that should have dropped the entry. It appears in the very next data phase after the lookup, with the old word on `rsp_data`. A valid bit that is lost or never set shows as a miss, with `rsp_data`=0, one cycle after the lookup that should have hit. A wrong ECC flag shows on `rsp_ecc` with the first hit after the load. The edge and priority corner cases are driven in back-to-back cycles, so an error in the edge register or in the order of set and clear shows within two cycles.

// File: rtl/rdbuf_pkg.sv
// Package: shared transfer-type encoding and helpers for the read buffer.
// Assumes the bus transfer type is a 2-bit field with the usual four codes.
package rdbuf_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    // True for transfers that carry a real read request.
    function automatic logic is_xfer(input logic [1:0] t);
        return (t == TR_NONSEQ) || (t == TR_SEQ);
    endfunction

    // True only for the first beat of a burst or a single access.
    function automatic logic is_nonseq(input logic [1:0] t);
        return t == TR_NONSEQ;
    endfunction

endpackage

// File: rtl/rdbuf_inval.sv
// Module: rdbuf_inval
// Collects every condition that drops the buffered entry into one kill
// strobe: array-done falling, emulation-tagged non-sequential access, and
// the software enable held low. Assumes arr_done is already synchronous.
module rdbuf_inval
    import rdbuf_pkg::*;
#(
    parameter int EMU_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       htrans,
    input  logic [EMU_W-1:0] emu_field,
    input  logic             buf_en,
    input  logic             arr_done,
    output logic             kill
);

    logic done_q;
    logic done_fall;
    logic emu_hit;

    // Track the previous array-done level; idle is assumed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b1;
        end else begin
            done_q <= arr_done;
        end
    end

    // Decode the three invalidation sources into one strobe.
    always_comb begin
        done_fall = done_q & ~arr_done;
        emu_hit   = is_nonseq(htrans) & (|emu_field);
        kill      = done_fall | emu_hit | ~buf_en;
    end

endmodule

// File: rtl/rdbuf_entry.sv
// Module: rdbuf_entry
// Single storage entry: valid bit, full address, data word and ECC flag.
// A kill strobe always wins over a load in the same cycle. An errored
// completion clears the valid bit instead of loading.
module rdbuf_entry #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              fill_valid,
    input  logic              fill_err,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_ecc1,
    output logic              ent_valid,
    output logic [ADDR_W-1:0] ent_addr,
    output logic [DATA_W-1:0] ent_data,
    output logic              ent_ecc
);

    logic do_load;
    logic do_clear;

    // Decide between clear, load and hold for this cycle.
    always_comb begin
        do_clear = kill | (fill_valid & fill_err);
        do_load  = fill_valid & ~fill_err & ~kill;
    end

    // Valid bit and ECC flag, both cleared by reset and by invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= 1'b0;
            ent_ecc   <= 1'b0;
        end else if (do_clear) begin
            ent_valid <= 1'b0;
            ent_ecc   <= 1'b0;
        end else if (do_load) begin
            ent_valid <= 1'b1;
            ent_ecc   <= fill_ecc1;
        end
    end

    // Address and data payload, written only on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_addr <= '0;
            ent_data <= '0;
        end else if (do_load) begin
            ent_addr <= fill_addr;
            ent_data <= fill_data;
        end
    end

endmodule

// File: rtl/rdbuf_lookup.sv
// Module: rdbuf_lookup
// Compares the address phase with the stored entry and registers the
// data-phase response. A cycle that invalidates never reports a hit.
// Miss cycles drive zero data so that no stale word leaks to the bus.
module rdbuf_lookup #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              kill,
    input  logic              ent_valid,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [DATA_W-1:0] ent_data,
    input  logic              ent_ecc,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_ecc
);

    logic hit_now;

    // Hit decision for the current address phase.
    always_comb begin
        hit_now = lookup & ent_valid & ~kill & (haddr == ent_addr);
    end

    // Register the data-phase response in the first data cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit  <= 1'b0;
            rsp_data <= '0;
            rsp_ecc  <= 1'b0;
        end else begin
            rsp_hit  <= hit_now;
            rsp_data <= hit_now ? ent_data : '0;
            rsp_ecc  <= hit_now & ent_ecc;
        end
    end

endmodule

// File: rtl/flash_rdbuf.sv
// Module: flash_rdbuf
// Single-entry holding buffer between a bus read port and a flash array.
// Assumes one completion at a time from the array and a 2-bit transfer
// type on the bus side. The emulation field lies in haddr[EMU_HI:EMU_LO].
module flash_rdbuf
    import rdbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int EMU_LO = 24,
    parameter int EMU_HI = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        htrans,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              buf_en,
    input  logic              arr_done,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_err,
    input  logic              fill_ecc1,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_ecc
);

    localparam int EMU_W = EMU_HI - EMU_LO + 1;

    logic              kill;
    logic              lookup;
    logic              ent_valid;
    logic [ADDR_W-1:0] ent_addr;
    logic [DATA_W-1:0] ent_data;
    logic              ent_ecc;

    // Classify the address phase as a real read request.
    always_comb begin
        lookup = is_xfer(htrans);
    end

    rdbuf_inval #(
        .EMU_W (EMU_W)
    ) u_inval (
        .clk       (clk),
        .rst_n     (rst_n),
        .htrans    (htrans),
        .emu_field (haddr[EMU_HI:EMU_LO]),
        .buf_en    (buf_en),
        .arr_done  (arr_done),
        .kill      (kill)
    );

    rdbuf_entry #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .kill       (kill),
        .fill_valid (fill_valid),
        .fill_err   (fill_err),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data),
        .fill_ecc1  (fill_ecc1),
        .ent_valid  (ent_valid),
        .ent_addr   (ent_addr),
        .ent_data   (ent_data),
        .ent_ecc    (ent_ecc)
    );

    rdbuf_lookup #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .lookup    (lookup),
        .haddr     (haddr),
        .kill      (kill),
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_ecc   (ent_ecc),
        .rsp_hit   (rsp_hit),
        .rsp_data  (rsp_data),
        .rsp_ecc   (rsp_ecc)
    );

endmodule

// File: rtl/flash_rdbuf_chk.sv
// Module: flash_rdbuf_chk
// Property checker bound into every flash_rdbuf instance. It watches
// ports and the kill / valid nets that separate submodules drive.
module flash_rdbuf_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        htrans,
    input logic              buf_en,
    input logic              arr_done,
    input logic              fill_valid,
    input logic              fill_err,
    input logic              kill,
    input logic              ent_valid,
    input logic              rsp_hit,
    input logic              rsp_ecc,
    input logic [DATA_W-1:0] rsp_data
);

    // R1: a clean completion with no invalidation leaves the entry valid
    a_r1_load_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_err && !kill) |=> ent_valid);

    // R2: a miss cycle never carries data
    a_r2_miss_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_data == '0));

    // R3: an array-done falling edge forbids a hit in the next data phase
    a_r3_fall_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(arr_done) && !arr_done) |=> !rsp_hit);

    // R5: enable low forbids a hit in the next data phase
    a_r5_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en |=> !rsp_hit);

    // R6: an errored completion leaves the entry invalid
    a_r6_err_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_err) |=> !ent_valid);

    // R7: the ECC flag is only reported together with a hit
    a_r7_ecc_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ecc |-> rsp_hit);

    // R8: IDLE and BUSY address phases never produce a hit
    a_r8_idle_busy_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !htrans[1] |=> !rsp_hit);

    // R9: invalidation wins over a same-cycle load
    a_r9_kill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !ent_valid);

endmodule

bind flash_rdbuf flash_rdbuf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .htrans     (htrans),
    .buf_en     (buf_en),
    .arr_done   (arr_done),
    .fill_valid (fill_valid),
    .fill_err   (fill_err),
    .kill       (kill),
    .ent_valid  (ent_valid),
    .rsp_hit    (rsp_hit),
    .rsp_ecc    (rsp_ecc),
    .rsp_data   (rsp_data)
);

// File: tb/flash_rdbuf_test.sv
// Bench for flash_rdbuf: a vector table walked by one loop, then directed
// reset tests. Inputs change at the falling edge, outputs are sampled 2
// time units after the rising edge that registers the response.
module flash_rdbuf_test;

    localparam int PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;

    localparam logic [1:0] I = 2'b00;
    localparam logic [1:0] B = 2'b01;
    localparam logic [1:0] N = 2'b10;
    localparam logic [1:0] S = 2'b11;

    localparam logic [31:0] A  = 32'h0000_1000;
    localparam logic [31:0] A4 = 32'h0000_1004;
    localparam logic [31:0] E  = 32'h0100_1000;
    localparam logic [31:0] O  = 32'h0000_2000;
    localparam logic [31:0] D1 = 32'hCAFE_0001;
    localparam logic [31:0] D2 = 32'hCAFE_0002;
    localparam logic [31:0] D3 = 32'hCAFE_0003;
    localparam logic [31:0] D4 = 32'hCAFE_0004;
    localparam logic [31:0] D5 = 32'hCAFE_0005;
    localparam logic [31:0] D6 = 32'hCAFE_0006;
    localparam logic [31:0] D7 = 32'hCAFE_0007;
    localparam logic [31:0] Z  = 32'h0;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  tr;
        logic [31:0] addr;
        logic        en;
        logic        done;
        logic        fv;
        logic        ferr;
        logic        fecc;
        logic [31:0] fdata;
        logic        xhit;
        logic        xecc;
        logic [31:0] xdata;
    } vec_t;

    localparam int NV = 34;

    // req, tr, addr, en, done, fv, ferr, fecc, fdata, xhit, xecc, xdata
    localparam vec_t VECS [NV] = '{
        '{4'd1, I, A,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, D1, 1'b0, 1'b0, Z },  // R1 load
        '{4'd2, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b0, D1},  // R2 hit
        '{4'd2, S, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b0, D1},  // R2 seq hit
        '{4'd2, S, A4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R2 other addr
        '{4'd8, B, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R8 busy
        '{4'd8, I, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R8 idle
        '{4'd8, S, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b0, D1},  // R8 still valid
        '{4'd4, N, E,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R4 emu nonseq
        '{4'd4, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R4 dropped
        '{4'd7, I, A,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, D2, 1'b0, 1'b0, Z },  // R7 load ecc
        '{4'd7, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b1, D2},  // R7 ecc hit
        '{4'd7, S, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b1, D2},  // R7 again
        '{4'd4, S, E,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R4 seq emu
        '{4'd4, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b1, D2},  // R4 kept
        '{4'd4, N, O,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R4 zero field
        '{4'd4, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b1, D2},  // R4 kept
        '{4'd3, N, A,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R3 fall
        '{4'd3, N, A,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R3 dropped
        '{4'd1, I, A,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, D3, 1'b0, 1'b0, Z },  // R1 reload
        '{4'd7, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b0, D3},  // R7 ecc clear
        '{4'd6, I, A,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, D4, 1'b0, 1'b0, Z },  // R6 err fill
        '{4'd6, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R6 invalid
        '{4'd1, I, A,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, D5, 1'b0, 1'b0, Z },  // R1 load
        '{4'd5, I, A,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R5 en low
        '{4'd5, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R5 dropped
        '{4'd9, I, A,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, D5, 1'b0, 1'b0, Z },  // R9 en vs load
        '{4'd9, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R9 invalid
        '{4'd9, I, A,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, D6, 1'b0, 1'b0, Z },  // R9 fall vs load
        '{4'd9, N, A,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R9 invalid
        '{4'd3, I, A,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, D7, 1'b0, 1'b0, Z },  // R3 low level
        '{4'd3, N, A,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b0, D7},  // R3 level kept
        '{4'd3, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b1, 1'b0, D7},  // R3 rise kept
        '{4'd5, N, A,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z },  // R5 lookup low
        '{4'd5, N, A,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z,  1'b0, 1'b0, Z }   // R5 stays invalid
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    htrans;
    logic [AW-1:0] haddr;
    logic          buf_en;
    logic          arr_done;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;
    logic          fill_err;
    logic          fill_ecc1;
    logic          rsp_hit;
    logic [DW-1:0] rsp_data;
    logic          rsp_ecc;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    flash_rdbuf uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .htrans     (htrans),
        .haddr      (haddr),
        .buf_en     (buf_en),
        .arr_done   (arr_done),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data),
        .fill_err   (fill_err),
        .fill_ecc1  (fill_ecc1),
        .rsp_hit    (rsp_hit),
        .rsp_data   (rsp_data),
        .rsp_ecc    (rsp_ecc)
    );

    task automatic drive(input vec_t v);
        htrans     = v.tr;
        haddr      = v.addr;
        buf_en     = v.en;
        arr_done   = v.done;
        fill_valid = v.fv;
        fill_addr  = v.addr;
        fill_data  = v.fdata;
        fill_err   = v.ferr;
        fill_ecc1  = v.fecc;
    endtask

    task automatic check(input string tag, input logic xhit, input logic xecc,
                         input logic [DW-1:0] xdata);
        n_checks++;
        if (rsp_hit !== xhit || rsp_ecc !== xecc || rsp_data !== xdata) begin
            n_fails++;
            $display("FAIL %s: hit/ecc/data got %b/%b/%h expected %b/%b/%h",
                     tag, rsp_hit, rsp_ecc, rsp_data, xhit, xecc, xdata);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 2000);
        n_fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary();
    end

    initial begin
        vec_t idle_v;
        vec_t fill_v;
        idle_v = '{4'd10, I, A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z, 1'b0, 1'b0, Z};
        fill_v = '{4'd10, I, A, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, D1, 1'b0, 1'b0, Z};

        // R10: reset held while a load and a lookup are presented
        rst_n = 1'b0;
        drive(fill_v);
        repeat (2) @(posedge clk);
        #2;
        check("R10 outputs in reset", 1'b0, 1'b0, Z);
        @(negedge clk);
        drive('{4'd10, N, A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z, 1'b0, 1'b0, Z});
        @(posedge clk);
        #2;
        check("R10 lookup during reset", 1'b0, 1'b0, Z);
        @(negedge clk);
        rst_n = 1'b1;
        drive('{4'd10, N, Z, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z, 1'b0, 1'b0, Z});
        @(posedge clk);
        #2;
        check("R10 invalid after reset", 1'b0, 1'b0, Z);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VECS[k]);
            @(posedge clk);
            #2;
            check($sformatf("R%0d vector %0d", VECS[k].req, k),
                  VECS[k].xhit, VECS[k].xecc, VECS[k].xdata);
        end

        // R10: reset in mid-run drops a valid ECC-tagged entry
        @(negedge clk);
        drive(fill_v);
        @(posedge clk);
        @(negedge clk);
        drive('{4'd10, N, A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z, 1'b0, 1'b0, Z});
        @(posedge clk);
        #2;
        check("R10 precondition hit", 1'b1, 1'b1, D1);
        @(negedge clk);
        rst_n = 1'b0;
        drive(idle_v);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive('{4'd10, N, A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, Z, 1'b0, 1'b0, Z});
        @(posedge clk);
        #2;
        check("R10 entry cleared by reset", 1'b0, 1'b0, Z);

        @(negedge clk);
        drive(idle_v);
        summary();
    end

endmodule